// File: doc/BRIEF.md
# Double-Wide Bit Funnel Shifter

This block shifts a pair of 128-bit operands by a small bit count. The pair is treated as one 256-bit word, with the first operand (`opnd_hi`) in the more significant half and the second operand (`opnd_lo`) in the less significant half. The shift count is between zero and seven bit positions. A left shift yields the upper half of the shifted word. A right shift yields the lower half. In both cases, bits move across the boundary between the two operands. This lets a datapath realign a bit stream that spans two registers without a full barrel shifter.

Bits are numbered big-endian: bit 0 is the leftmost bit. In the vectors it is the MSB, `[HALF_W-1]`. The datapath itself is combinational. The parameter `REG_OUT` selects whether a result register sits in front of the output port. Its default is 1, which gives a registered output.

Top module: `dwshift_unit`

## Requirements
- R1: The bits that cross the operand boundary land in the result as follows. For a left shift they fill the low `shamt` result bits. For a right shift they fill the high `shamt` result bits. Every other result bit comes from the operand on the same side.
- R2: With `dir_right`=0 (left), the result is bits [255:128] of `{opnd_hi,opnd_lo} << shamt`.
- R3: With `dir_right`=1 (right), the result is bits [127:0] of `{opnd_hi,opnd_lo} >> shamt`.
- R4: A count of 0 in left mode returns `opnd_hi` unchanged.
- R5: A count of 0 in right mode returns `opnd_lo` unchanged.
- R6: In left mode with count n>0, result bits [n-1:0] equal the top n bits of `opnd_lo`, bits [127:128-n].
- R7: In right mode with count n>0, result bits [127:128-n] equal the low n bits of `opnd_hi`, bits [n-1:0].
- R8: With `REG_OUT`=1, `res` is zero while reset is active. After reset, `res` shows the result for the inputs captured at the previous rising clock edge, so it changes only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_hi | input | 128 | Left (more significant) operand |
| opnd_lo | input | 128 | Right (less significant) operand |
| shamt | input | 3 | Shift count, 0 to 7 |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| res | output | 128 | Shifted 128-bit result |

## Verification
Two events can fall in the same cycle: the cross-boundary fill and a change of direction. In one cycle the fill comes from the second operand's top bits. In the next cycle it comes from the first operand's bottom bits. The bench sweeps every count with both directions, back to back, over operands whose two halves differ, so a fill taken from the wrong operand shows up at once. Each result is judged against a bit-position model that reads the joined word from the left. The bench also checks that a new input does not reach `res` before the clock edge.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } sh_dir_e;
endpackage

// File: rtl/dws_join.sv
module dws_join #(
  parameter int HALF_W = 128
) (
  input  logic [HALF_W-1:0]   hi,
  input  logic [HALF_W-1:0]   lo,
  output logic [2*HALF_W-1:0] joined
);
  // first operand takes the more significant (leftmost) half
  assign joined = {hi, lo};
endmodule

// File: rtl/dws_funnel.sv
module dws_funnel
  import dws_pkg::*;
#(
  parameter int HALF_W = 128,
  parameter int CNT_W  = 3
) (
  input  logic [2*HALF_W-1:0] joined,
  input  logic [CNT_W-1:0]    amt,
  input  sh_dir_e             dir,
  output logic [HALF_W-1:0]   y,
  output logic [HALF_W-1:0]   cross_bits
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] shl_w;
  logic [FULL_W-1:0] shr_w;
  logic [HALF_W-1:0] hi_w;
  logic [HALF_W-1:0] lo_w;

  function automatic logic [FULL_W-1:0] shift_word(input logic [FULL_W-1:0] v,
                                                    input logic [CNT_W-1:0] n,
                                                    input logic right);
    return right ? (v >> n) : (v << n);
  endfunction

  assign hi_w  = joined[FULL_W-1:HALF_W];
  assign lo_w  = joined[HALF_W-1:0];
  assign shl_w = shift_word(joined, amt, 1'b0);
  assign shr_w = shift_word(joined, amt, 1'b1);

  always_comb begin
    if (dir == SH_LEFT) begin
      y          = shl_w[FULL_W-1:HALF_W];
      cross_bits = lo_w >> (HALF_W - int'(amt));
    end else begin
      y          = shr_w[HALF_W-1:0];
      cross_bits = hi_w << (HALF_W - int'(amt));
    end
  end
endmodule

// File: rtl/dws_outstage.sv
module dws_outstage #(
  parameter int W   = 128,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_comb
      logic unused_w;
      assign unused_w = clk ^ rst_n;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dwshift_unit.sv
module dwshift_unit
  import dws_pkg::*;
#(
  parameter int HALF_W  = 128,
  parameter int CNT_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] opnd_hi,
  input  logic [HALF_W-1:0] opnd_lo,
  input  logic [CNT_W-1:0]  shamt,
  input  logic              dir_right,
  output logic [HALF_W-1:0] res
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] joined_w;
  logic [HALF_W-1:0] shifted_w;
  logic [HALF_W-1:0] cross_bits;
  sh_dir_e           dir_w;

  assign dir_w = dir_right ? SH_RIGHT : SH_LEFT;

  dws_join #(.HALF_W(HALF_W)) u_join (
    .hi     (opnd_hi),
    .lo     (opnd_lo),
    .joined (joined_w)
  );

  dws_funnel #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_funnel (
    .joined     (joined_w),
    .amt        (shamt),
    .dir        (dir_w),
    .y          (shifted_w),
    .cross_bits (cross_bits)
  );

  dws_outstage #(.W(HALF_W), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (shifted_w),
    .q     (res)
  );
endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
  parameter int HALF_W  = 128,
  parameter int CNT_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] opnd_hi,
  input logic [HALF_W-1:0] opnd_lo,
  input logic [CNT_W-1:0]  shamt,
  input logic              dir_right,
  input logic [HALF_W-1:0] cross_bits,
  input logic [HALF_W-1:0] res
);
  logic [HALF_W-1:0] aq, bq, xq;
  logic [CNT_W-1:0]  nq;
  logic              dq, vq;

  generate
    if (REG_OUT) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          aq <= '0; bq <= '0; xq <= '0; nq <= '0; dq <= 1'b0; vq <= 1'b0;
        end else begin
          aq <= opnd_hi; bq <= opnd_lo; xq <= cross_bits;
          nq <= shamt;   dq <= dir_right; vq <= 1'b1;
        end
      end
    end else begin : g_flat
      assign aq = opnd_hi; assign bq = opnd_lo; assign xq = cross_bits;
      assign nq = shamt;   assign dq = dir_right; assign vq = 1'b1;
    end
  endgenerate

  function automatic logic [HALF_W-1:0] low_ones(input logic [CNT_W-1:0] n);
    return ~({HALF_W{1'b1}} << n);
  endfunction

  function automatic logic [HALF_W-1:0] fill_mask(input logic [CNT_W-1:0] n, input logic r);
    return r ? ~({HALF_W{1'b1}} >> n) : low_ones(n);
  endfunction

  // R1: crossing bits from the funnel appear in the fill positions of res
  a_r1_cross_fill: assert property (@(posedge clk) disable iff (!rst_n)
    vq |-> ((res & fill_mask(nq, dq)) == xq));

  a_r2_left_body: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && !dq) |-> ((res >> nq) == (aq & ({HALF_W{1'b1}} >> nq))));

  a_r3_right_body: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && dq) |-> ((res << nq) == (bq & ({HALF_W{1'b1}} << nq))));

  a_r4_zero_left: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && !dq && nq == '0) |-> (res == aq));

  a_r5_zero_right: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && dq && nq == '0) |-> (res == bq));

  a_r6_left_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && !dq && nq != '0) |-> ((res & low_ones(nq)) == (bq >> (HALF_W - int'(nq)))));

  a_r7_right_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (vq && dq && nq != '0) |-> ((res >> (HALF_W - int'(nq))) == (aq & low_ones(nq))));
endmodule

bind dwshift_unit dws_chk #(
  .HALF_W (HALF_W),
  .CNT_W  (CNT_W),
  .REG_OUT(REG_OUT)
) u_dws_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opnd_hi    (opnd_hi),
  .opnd_lo    (opnd_lo),
  .shamt      (shamt),
  .dir_right  (dir_right),
  .cross_bits (cross_bits),
  .res        (res)
);

// File: tb/tb_dwshift_unit.sv
`timescale 1ns/1ps
module tb_dwshift_unit;
  localparam int HW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] opnd_hi = '0;
  logic [HW-1:0] opnd_lo = '0;
  logic [2:0]    shamt = '0;
  logic          dir_right = 1'b0;
  logic [HW-1:0] res;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dwshift_unit dut (
    .clk(clk), .rst_n(rst_n), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
    .shamt(shamt), .dir_right(dir_right), .res(res)
  );

  // bit at position p counted from the left of the joined 256-bit word
  function automatic logic jbit(input logic [HW-1:0] a, input logic [HW-1:0] b, input int p);
    if (p < 0 || p >= 2*HW) return 1'b0;
    if (p < HW) return a[HW-1-p];
    return b[2*HW-1-p];
  endfunction

  function automatic logic [HW-1:0] model(input logic [HW-1:0] a, input logic [HW-1:0] b,
                                          input int n, input bit right);
    logic [HW-1:0] r;
    for (int p = 0; p < HW; p++)
      r[HW-1-p] = right ? jbit(a, b, HW + p - n) : jbit(a, b, p + n);
    return r;
  endfunction

  task automatic check(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [HW-1:0] a, input logic [HW-1:0] b, input int n, input bit r);
    @(negedge clk);
    opnd_hi = a; opnd_lo = b; shamt = 3'(n); dir_right = r;
    @(negedge clk);
  endtask

  task automatic sweep(input logic [HW-1:0] a, input logic [HW-1:0] b);
    for (int n = 0; n < 8; n++) begin
      for (int r = 0; r < 2; r++) begin
        apply(a, b, n, bit'(r));
        check(r ? "R3 right sweep" : "R2 left sweep", res, model(a, b, n, bit'(r)));
        if (n == 0) check(r ? "R5 zero count right" : "R4 zero count left", res, r ? b : a);
        if (n != 0 && r == 0)
          check("R6 left fill", res & ((HW'(1) << n) - 1), b >> (HW - n));
        if (n != 0 && r == 1)
          check("R7 right fill", res >> (HW - n), a & ((HW'(1) << n) - 1));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] ra, rb;
    opnd_hi = {4{32'hDEADBEEF}}; opnd_lo = {4{32'h0F0F1234}};
    repeat (3) @(negedge clk);
    check("R8 reset zero", res, '0);
    rst_n = 1'b1;

    // R1: all-ones left operand, zero right operand; fill bits come only from the other half
    apply({HW{1'b1}}, '0, 3, 1'b0);
    check("R1 left fill from second operand", res, {{(HW-3){1'b1}}, 3'b000});
    apply({HW{1'b1}}, '0, 5, 1'b1);
    check("R1 right fill from first operand", res, {5'b11111, {(HW-5){1'b0}}});

    // R8: new input is not visible before the next rising edge
    @(negedge clk);
    opnd_hi = '0; opnd_lo = {HW{1'b1}}; shamt = 3'd0; dir_right = 1'b1;
    #1 check("R8 held until edge", res, {5'b11111, {(HW-5){1'b0}}});
    @(negedge clk);
    check("R8 updated after edge", res, {HW{1'b1}});

    sweep({4{32'hDEADBEEF}}, {4{32'h13579BDF}});
    sweep({HW{1'b1}}, '0);
    sweep('0, {HW{1'b1}});
    sweep({64{2'b10}}, {64{2'b01}});
    for (int k = 0; k < 4; k++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      sweep(ra, rb);
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule